// File: doc/BRIEF.md
# Pin-Multiplexed General-Purpose I/O Port

This block is one 16-pin I/O port. Each pin is either under direct software control (GPIO mode) or handed to one of four on-chip peripheral channels (peripheral mode). A per-pin mode bit chooses between the two, and a 2-bit selector per pin picks the peripheral channel. In GPIO mode the pin's direction and output level come from two registers. Software changes these registers only by writing ones to a set address or a clear address. An input-enable bit per pin decides whether the pad level is sampled into the data register.

Software talks to the port through a simple single-cycle register bus. The write takes effect on the clock edge where `reg_we` is high. The read data follows `reg_addr` combinationally. The pad side is a plain input/output/output-enable triple per pin. Peripheral channels hand in their output and output-enable vectors. They get back the synchronised pad level, routed only to the channel that each pin selects.

Top module: `gpm_port`

## Requirements
- R1: After reset, the mode, selector, direction, data and input-enable registers are all zero. `pad_oe`, `pad_out` and `fn_in` are all zero.
- R2: The register addresses are: 0 mode (read/write, bit n = pin n, 1 = peripheral), 1 selector (read/write, pin n at bits 2n+1:2n), 8 input enable (read/write, bit n = pin n). Bits above the register width are ignored.
- R3: Direction is read at address 2, 3 or 4. Address 3 sets and address 4 clears only the bits written as 1. A write to address 2 has no effect. Direction 1 means output.
- R4: A pad input change is visible on a read of address 5 from the third rising edge after the pad changes, through a two-stage synchroniser.
- R5: A pin's data bit follows its synchronised pad level only while its input-enable bit is 1 and its direction is 0. Sampling takes precedence over a data set or clear write in the same cycle. With input enable 0 the pad level has no effect.
- R6: Data is read at address 5, 6 or 7. Address 6 sets and address 7 clears only the bits written as 1. A write to address 5 has no effect. Bits 31:16 of every read are zero.
- R7: For a pin in GPIO mode, `pad_oe` equals its direction bit and `pad_out` equals its data bit. Peripheral signals have no effect on such a pin.
- R8: For a pin in peripheral mode, `pad_oe` and `pad_out` are taken from the selected channel k. Bit k*16+n of `fn_oe` and `fn_out` belongs to pin n.
- R9: Bit k*16+n of `fn_in` carries pin n's synchronised pad level only when pin n is in peripheral mode with selector k. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| fn_out | input | 64 | Peripheral output levels, channel k at bits k*16+15:k*16 |
| fn_oe | input | 64 | Peripheral output enables, same layout |
| fn_in | output | 64 | Synchronised pad levels routed to the selected channel |

## Verification
The hardest case to reach is a clash between sampling and a software write. A pin must be an input with sampling on and a high pad while a clear write targets it. Afterwards the same pin must turn into an output whose level software can then clear. The stimulus builds this up in order. It first enables sampling on the upper byte and waits out the synchroniser. It then steps the pad to measure the three-edge latency and issues the clear against live sampling. Last it flips the pin's direction and proves that the pad no longer reaches the data bit.

// File: rtl/gpm_pkg.sv
// Package: shared address map and sizing constants for the GPIO mux port.
// Assumes a 4-bit register address space.
package gpm_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE     = 4'd0,
        A_SEL      = 4'd1,
        A_DIR      = 4'd2,
        A_DIR_SET  = 4'd3,
        A_DIR_CLR  = 4'd4,
        A_DATA     = 4'd5,
        A_DATA_SET = 4'd6,
        A_DATA_CLR = 4'd7,
        A_INEN     = 4'd8
    } gpm_addr_e;

endpackage

// File: rtl/gpm_sync.sv
// Module: per-pin multi-stage synchroniser for pad inputs.
// Assumes pad inputs are asynchronous to clk. Every stage resets to 0.
module gpm_sync #(
    parameter int PINS   = 16,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);

    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_pin
            logic [STAGES-1:0] chain_q;

            // Shift the pad level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in[p]};
            end

            assign sync_out[p] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gpm_regs.sv
// Module: register file of the port. It holds mode, selector, direction,
// data and input enable, with set/clear aliases for direction and data.
// Assumes a single-cycle write strobe and that SEL_W*PINS fits BUS_W.
module gpm_regs
    import gpm_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int SEL_W = 2,
    parameter int BUS_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    input  logic [PINS-1:0]       sync_in,
    output logic [PINS-1:0]       mode_q,
    output logic [PINS*SEL_W-1:0] sel_q,
    output logic [PINS-1:0]       dir_q,
    output logic [PINS-1:0]       data_q,
    output logic [PINS-1:0]       inen_q
);

    localparam int SEL_BITS = PINS * SEL_W;

    gpm_addr_e        waddr;
    logic [PINS-1:0]  wbits;
    logic [PINS-1:0]  sample_mask;
    logic [PINS-1:0]  data_nxt;
    logic             unused_wdata;

    assign waddr        = gpm_addr_e'(addr);
    assign wbits        = wdata[PINS-1:0];
    assign unused_wdata = ^wdata;
    // Pins whose data bit follows the pad: input direction with sampling on.
    assign sample_mask  = inen_q & ~dir_q;

    // Update the configuration registers on writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            sel_q  <= '0;
            dir_q  <= '0;
            inen_q <= '0;
        end else if (we) begin
            case (waddr)
                A_MODE:    mode_q <= wbits;
                A_SEL:     sel_q  <= wdata[SEL_BITS-1:0];
                A_DIR_SET: dir_q  <= dir_q | wbits;
                A_DIR_CLR: dir_q  <= dir_q & ~wbits;
                A_INEN:    inen_q <= wbits;
                default:   ;
            endcase
        end
    end

    // Next data value: software set/clear first, pad sampling overrides.
    always_comb begin
        data_nxt = data_q;
        if (we && waddr == A_DATA_SET) data_nxt = data_nxt | wbits;
        if (we && waddr == A_DATA_CLR) data_nxt = data_nxt & ~wbits;
        data_nxt = (data_nxt & ~sample_mask) | (sync_in & sample_mask);
    end

    // Register the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_nxt;
    end

    // Combinational readback, zero-extended to the bus width.
    always_comb begin
        case (gpm_addr_e'(addr))
            A_MODE:                         rdata = BUS_W'(mode_q);
            A_SEL:                          rdata = BUS_W'(sel_q);
            A_DIR, A_DIR_SET, A_DIR_CLR:    rdata = BUS_W'(dir_q);
            A_DATA, A_DATA_SET, A_DATA_CLR: rdata = BUS_W'(data_q);
            A_INEN:                         rdata = BUS_W'(inen_q);
            default:                        rdata = '0;
        endcase
    end

    // R3: a set write ORs the written ones into direction.
    assert_dir_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == A_DIR_SET) |=> dir_q == ($past(dir_q) | $past(wbits)));

    // R3: direction moves only on its set or clear alias.
    assert_dir_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (waddr == A_DIR_SET || waddr == A_DIR_CLR)) |=> $stable(dir_q));

    // R5: sampled pins copy the synchronised pad level.
    assert_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_mask != '0) |=>
        ((data_q ^ $past(sync_in)) & $past(sample_mask)) == '0);

    // R6: without a data write or sampling, data holds.
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && (waddr == A_DATA_SET || waddr == A_DATA_CLR)) && sample_mask == '0)
        |=> $stable(data_q));

endmodule

// File: rtl/gpm_route.sv
// Module: per-pin routing between GPIO registers, peripheral channels and
// the pad. Assumes FUNCS is a power of two, so every selector value is valid.
module gpm_route #(
    parameter int PINS  = 16,
    parameter int FUNCS = 4,
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       mode_q,
    input  logic [PINS*SEL_W-1:0] sel_q,
    input  logic [PINS-1:0]       dir_q,
    input  logic [PINS-1:0]       data_q,
    input  logic [PINS-1:0]       sync_in,
    input  logic [FUNCS*PINS-1:0] fn_out,
    input  logic [FUNCS*PINS-1:0] fn_oe,
    output logic [FUNCS*PINS-1:0] fn_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe
);

    genvar p, k;
    generate
        for (p = 0; p < PINS; p++) begin : g_pin
            logic [SEL_W-1:0] sel;
            logic [FUNCS-1:0] oe_col;
            logic [FUNCS-1:0] out_col;
            logic [FUNCS-1:0] in_col;

            assign sel = sel_q[p*SEL_W +: SEL_W];

            for (k = 0; k < FUNCS; k++) begin : g_fn
                assign oe_col[k] = fn_oe[k*PINS + p];
                assign out_col[k] = fn_out[k*PINS + p];
                // Return the pad level only to the selected channel.
                assign in_col[k] = mode_q[p] && (sel == SEL_W'(k)) && sync_in[p];
                assign fn_in[k*PINS + p] = in_col[k];
            end

            // Pad drive: peripheral channel in peripheral mode, registers otherwise.
            always_comb begin
                if (mode_q[p]) begin
                    pad_oe[p]  = oe_col[sel];
                    pad_out[p] = out_col[sel];
                end else begin
                    pad_oe[p]  = dir_q[p];
                    pad_out[p] = data_q[p];
                end
            end

            // R9: at most one channel sees this pin's input.
            assert_fn_in_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(in_col));

            // R7: a GPIO-mode input pin never drives the pad.
            assert_gpio_input_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!mode_q[p] && !dir_q[p]) |-> !pad_oe[p]);
        end
    endgenerate

endmodule

// File: rtl/gpm_port.sv
// Module: top of the 16-pin GPIO port with per-pin function mux.
// Assumes a single clock domain for the register bus and the peripherals.
// Pad inputs are asynchronous.
module gpm_port
    import gpm_pkg::*;
#(
    parameter int PINS     = 16,
    parameter int FUNCS    = 4,
    parameter int BUS_W    = 32,
    parameter int SYNC_LEN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [BUS_W-1:0]      reg_wdata,
    output logic [BUS_W-1:0]      reg_rdata,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    input  logic [FUNCS*PINS-1:0] fn_out,
    input  logic [FUNCS*PINS-1:0] fn_oe,
    output logic [FUNCS*PINS-1:0] fn_in
);

    localparam int SEL_W = $clog2(FUNCS);

    logic [PINS-1:0]       sync_lvl;
    logic [PINS-1:0]       mode_q;
    logic [PINS*SEL_W-1:0] sel_q;
    logic [PINS-1:0]       dir_q;
    logic [PINS-1:0]       data_q;
    logic [PINS-1:0]       inen_q;

    gpm_sync #(.PINS(PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_lvl)
    );

    gpm_regs #(.PINS(PINS), .SEL_W(SEL_W), .BUS_W(BUS_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .sync_in (sync_lvl),
        .mode_q  (mode_q),
        .sel_q   (sel_q),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .inen_q  (inen_q)
    );

    gpm_route #(.PINS(PINS), .FUNCS(FUNCS), .SEL_W(SEL_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_q  (mode_q),
        .sel_q   (sel_q),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .sync_in (sync_lvl),
        .fn_out  (fn_out),
        .fn_oe   (fn_oe),
        .fn_in   (fn_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // R1: one cycle after reset is released, no pad is driven.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == '0);

endmodule

// File: tb/gpm_port_test.sv
`timescale 1ns/1ps
module gpm_port_test;

    localparam int K_RD  = 0;
    localparam int K_OE  = 1;
    localparam int K_OUT = 2;
    localparam int K_FIN = 3;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [15:0] pad_in = 0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic [63:0] fn_out = 0;
    logic [63:0] fn_oe = 0;
    logic [63:0] fn_in;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;
    sb_item_t sb[$];

    always #10 clk = ~clk;

    gpm_port uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe),
        .fn_in(fn_in)
    );

    // Monitor: pop one expected item each falling edge and compare.
    always @(negedge clk) begin
        sb_item_t    it;
        logic [63:0] act;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = {32'h0, reg_rdata};
                K_OE:    act = {48'h0, pad_oe};
                K_OUT:   act = {48'h0, pad_out};
                default: act = fn_in;
            endcase
            n_total++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 0;
    endtask

    task automatic expect_val(input int kind, input logic [3:0] a,
                              input logic [63:0] e, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        sb.push_back('{kind: kind, exp: e, tag: tag});
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1 reset state
        expect_val(K_RD, 0, 0, "R1 mode");
        expect_val(K_RD, 1, 0, "R1 sel");
        expect_val(K_RD, 2, 0, "R1 dir");
        expect_val(K_RD, 5, 0, "R1 data");
        expect_val(K_RD, 8, 0, "R1 inen");
        expect_val(K_OE, 0, 0, "R1 pad_oe");
        expect_val(K_OUT, 0, 0, "R1 pad_out");
        expect_val(K_FIN, 0, 0, "R1 fn_in");

        // R3 direction set/clear aliases
        wr(3, 32'h0000_00F0);
        expect_val(K_RD, 2, 64'h00F0, "R3 dir set");
        wr(3, 32'hFFFF_0003);
        expect_val(K_RD, 3, 64'h00F3, "R3 dir set only ones");
        wr(4, 32'h0000_0010);
        expect_val(K_RD, 4, 64'h00E3, "R3 dir clear");
        expect_val(K_OE, 0, 64'h00E3, "R7 pad_oe follows dir");

        // R6 data set/clear aliases
        wr(6, 32'h0000_00A1);
        expect_val(K_RD, 5, 64'h00A1, "R6 data set");
        expect_val(K_OUT, 0, 64'h00A1, "R7 pad_out follows data");
        wr(7, 32'h0000_0001);
        expect_val(K_RD, 6, 64'h00A0, "R6 data clear");

        // R5 sampling gated by input enable (pin 2 not enabled)
        pad_in = 16'h5A04;
        wr(8, 32'h0000_FF00);
        expect_val(K_RD, 8, 64'hFF00, "R2 inen readback");
        idle(4);
        expect_val(K_RD, 5, 64'h5AA0, "R5 sampling gated by inen");

        // R4 latency: pad bit 8 rises, visible on the third edge
        @(posedge clk); #2;
        pad_in = 16'h5B04;
        expect_val(K_RD, 5, 64'h5AA0, "R4 edge 1");
        expect_val(K_RD, 5, 64'h5AA0, "R4 edge 2");
        expect_val(K_RD, 5, 64'h5BA0, "R4 edge 3");

        // R5 sampling beats a clear write
        wr(7, 32'h0000_FF00);
        expect_val(K_RD, 5, 64'h5BA0, "R5 sample over clear");

        // R3/R6 writes to the base addresses are ignored
        wr(2, 32'h0000_FFFF);
        expect_val(K_RD, 2, 64'h00E3, "R3 base dir write ignored");
        wr(5, 32'h0000_FFFF);
        expect_val(K_RD, 5, 64'h5BA0, "R6 base data write ignored");

        // R5 pin 8 becomes output: pad no longer reaches data
        wr(3, 32'h0000_0100);
        wr(7, 32'h0000_0100);
        expect_val(K_RD, 5, 64'h5AA0, "R5 output pin not sampled");
        expect_val(K_OE, 0, 64'h01E3, "R7 pin 8 driven");
        expect_val(K_OUT, 0, 64'h5AA0, "R7 pin 8 low");

        // R2/R8/R9 peripheral mode on pins 4..7, channel k on pin 4+k
        fn_oe  = {16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF};
        fn_out = {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000};
        pad_in = 16'h5BF4;
        wr(1, 32'h0000_E400);
        wr(0, 32'hFFFF_00F0);
        expect_val(K_RD, 0, 64'h00F0, "R2 mode readback");
        expect_val(K_RD, 1, 64'hE400, "R2 sel field positions");
        idle(3);
        expect_val(K_OE, 0, 64'h0153, "R8 pad_oe from channel");
        expect_val(K_OUT, 0, 64'h5A60, "R8 pad_out from channel");
        expect_val(K_FIN, 0, 64'h0080_0040_0020_0010, "R9 fn_in routing");
        expect_val(K_RD, 9, 0, "R2 unmapped address reads zero");

        idle(2);
        done = 1;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_total++;
                    n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
            wait (done);
        join_any
        #1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule